// File: doc/BRIEF.md
# Cascadable Binary Counter

This block is a synchronous binary up counter built from identical 4-bit stages chained through their carry outputs. Each stage can be cleared to zero, loaded in parallel, made to advance by one, or left holding its value. All of these take effect only on a rising clock edge. Each stage has two count enables. The "parallel" enable goes to every stage. The "trickle" enable goes only to the lowest stage, and each higher stage takes the carry of the stage below it as its trickle enable. With the default parameters, two stages form an 8-bit counter.

A wrap-mode input makes the count range programmable. In free mode the counter wraps from all ones to zero. In reload mode the terminal carry drives a parallel load, so the counter restarts at the value on `din`. In truncate mode a match between the count and `din` forces a clear on the next edge, so the sequence ends at `din`.

Each stage decodes its inputs into one of four named actions, in descending priority: ACT_CLEAR, ACT_LOAD, ACT_COUNT, ACT_HOLD. The action is applied to the stage register at the next edge. The wrap modes are WRAP_FREE (code 00), WRAP_RELOAD (code 01), WRAP_TRUNC (code 10) and WRAP_SPARE (code 11, which behaves like free).

Top module: `bin_count_chain`

## Requirements
- R1: When `clr_n` is low, `q` becomes 0 at the next rising edge, whatever the load, enable and mode inputs are. Neither clear nor load changes `q` before that edge.
- R2: When `clr_n` is high and `ld_n` is low, `q` takes the value of `din` at the next rising edge, whether or not the enables are high.
- R3: When neither clear nor load acts and both `en_p` and `en_t` are high, `q` increments by one at each rising edge, wrapping from 8'hFF to 8'h00 in wrap modes 00 and 11.
- R4: When neither clear nor load acts and `en_p` or `en_t` is low, `q` holds its value.
- R5: `carry` is high exactly when `q` is 8'hFF and `en_t` is high. It follows these inputs without waiting for a clock edge.
- R6: The upper nibble `q[7:4]` advances only at the edge where a count moves the lower nibble `q[3:0]` from 4'hF to 4'h0, so 8'h0F counts to 8'h10.
- R7: In wrap mode 01, whenever `carry` is high, the next rising edge loads `din` into `q`. With both enables high, the counter cycles from `din` up to 8'hFF and then returns to `din`.
- R8: In wrap mode 10, whenever `q` equals `din`, the next rising edge clears `q` to 0, even if the enables are low. With both enables high, the sequence runs from 0 through `din` and then back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Parallel count enable, shared by all stages |
| en_t | input | 1 | Trickle count enable of the lowest stage; also qualifies `carry` |
| wrap_mode | input | 2 | 00 free, 01 reload din on carry, 10 clear when q equals din, 11 free |
| din | input | 8 | Parallel load data, reload start value or truncation end value |
| q | output | 8 | Current count |
| carry | output | 1 | Terminal carry of the top stage |

## Verification
The count is the only state in this block, so an error in any stage register shows on `q` at the edge that follows it, and `carry` shows it as soon as `q` is wrong. A fault in the priority decode or in the wrap-mode logic appears on `q` at the first edge where two controls compete or where a terminal condition arises. A broken link between stages shows only at the 8'h0F to 8'h10 step or at the 8'hFF terminal count. The directed cases therefore step through those boundaries. They are mixed with random control patterns that are checked against a reference next-state function, once per edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'b00,
        ACT_COUNT = 2'b01,
        ACT_LOAD  = 2'b10,
        ACT_CLEAR = 2'b11
    } stage_act_e;

    typedef enum logic [1:0] {
        WRAP_FREE   = 2'b00,
        WRAP_RELOAD = 2'b01,
        WRAP_TRUNC  = 2'b10,
        WRAP_SPARE  = 2'b11
    } wrap_mode_e;

endpackage

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         rco
);

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

    stage_act_e   act;
    logic [W-1:0] cnt_r;

    // priority decode: clear, then load, then count, else hold
    always_comb begin
        if (!clr_n)             act = ACT_CLEAR;
        else if (!ld_n)         act = ACT_LOAD;
        else if (en_p && en_t)  act = ACT_COUNT;
        else                    act = ACT_HOLD;
    end

    // state register
    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR: cnt_r <= '0;
            ACT_LOAD:  cnt_r <= d;
            ACT_COUNT: cnt_r <= cnt_r + W'(1);
            ACT_HOLD:  cnt_r <= cnt_r;
        endcase
    end

    // outputs
    always_comb begin
        q   = cnt_r;
        rco = en_t && (cnt_r == TOP_VAL);
    end

    logic armed;
    always_ff @(posedge clk) armed <= 1'b1;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (q == '0));                                        // R1
    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !ld_n) |=> (q == $past(d)));                        // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && ld_n && en_p && en_t) |=> (q == $past(q) + W'(1))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q));          // R4

endmodule

// File: rtl/cnt_wrap_ctl.sv
module cnt_wrap_ctl
    import cnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   wrap_mode,
    input  logic [W-1:0] q,
    input  logic [W-1:0] din,
    input  logic         carry,
    input  logic         clr_n,
    input  logic         ld_n,
    output logic         eff_clr_n,
    output logic         eff_ld_n
);

    wrap_mode_e mode;
    logic       end_hit;

    always_comb begin
        mode      = wrap_mode_e'(wrap_mode);
        end_hit   = (q == din);
        eff_clr_n = clr_n;
        eff_ld_n  = ld_n;
        unique case (mode)
            WRAP_RELOAD: eff_ld_n  = ld_n && !carry;
            WRAP_TRUNC:  eff_clr_n = clr_n && !end_hit;
            WRAP_FREE,
            WRAP_SPARE:  ;
        endcase
    end

endmodule

// File: rtl/bin_count_chain.sv
module bin_count_chain
    import cnt_pkg::*;
#(
    parameter int STAGE_W  = 4,
    parameter int N_STAGES = 2,
    localparam int TOTAL_W = STAGE_W * N_STAGES
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               ld_n,
    input  logic               en_p,
    input  logic               en_t,
    input  logic [1:0]         wrap_mode,
    input  logic [TOTAL_W-1:0] din,
    output logic [TOTAL_W-1:0] q,
    output logic               carry
);

    logic [N_STAGES:0] t_chain;
    logic              eff_clr_n;
    logic              eff_ld_n;

    assign t_chain[0] = en_t;
    assign carry      = t_chain[N_STAGES];

    cnt_wrap_ctl #(.W(TOTAL_W)) u_wrap (
        .wrap_mode (wrap_mode),
        .q         (q),
        .din       (din),
        .carry     (carry),
        .clr_n     (clr_n),
        .ld_n      (ld_n),
        .eff_clr_n (eff_clr_n),
        .eff_ld_n  (eff_ld_n)
    );

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        cnt_stage #(.W(STAGE_W)) u_stage (
            .clk   (clk),
            .clr_n (eff_clr_n),
            .ld_n  (eff_ld_n),
            .en_p  (en_p),
            .en_t  (t_chain[i]),
            .d     (din[i*STAGE_W +: STAGE_W]),
            .q     (q[i*STAGE_W +: STAGE_W]),
            .rco   (t_chain[i+1])
        );
    end

    logic armed;
    always_ff @(posedge clk) armed <= 1'b1;

    AST_CARRY_TERMINAL: assert property (@(posedge clk) disable iff (!armed)
        carry |-> (q == {TOTAL_W{1'b1}} && en_t));                          // R5
    AST_RELOAD_START: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && wrap_mode == 2'b01 && carry) |=> (q == $past(din)));      // R7
    AST_TRUNC_END: assert property (@(posedge clk) disable iff (!armed)
        (wrap_mode == 2'b10 && q == din) |=> (q == '0));                    // R8

    if (N_STAGES >= 2) begin : g_casc_chk
        AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (!armed)
            (clr_n && ld_n && en_p && en_t && wrap_mode == 2'b00 &&
             q[STAGE_W-1:0] == {STAGE_W{1'b1}})
            |=> (q[2*STAGE_W-1:STAGE_W] ==
                 $past(q[2*STAGE_W-1:STAGE_W]) + STAGE_W'(1)));              // R6
    end

endmodule

// File: tb/tb_bin_count_chain.sv
`timescale 1ns/1ps
module tb_bin_count_chain;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [1:0] wrap_mode = 2'b00;
    logic [7:0] din = 8'h00;
    logic [7:0] q;
    logic       carry;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [7:0] model;
    bit known = 0;

    always #4 clk = ~clk;

    bin_count_chain dut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
        .wrap_mode(wrap_mode), .din(din), .q(q), .carry(carry)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: act=%0d exp=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic exp_carry(logic [7:0] cur, logic t);
        return (cur == 8'hFF) && t;
    endfunction

    function automatic logic [7:0] next_val(logic [7:0] cur, logic c, logic l,
                                            logic p, logic t, logic [1:0] m,
                                            logic [7:0] d);
        logic do_clr, do_ld;
        do_clr = !c || (m == 2'b10 && cur == d);
        do_ld  = !l || (m == 2'b01 && exp_carry(cur, t));
        if (do_clr)      return 8'h00;
        else if (do_ld)  return d;
        else if (p && t) return cur + 8'd1;
        else             return cur;
    endfunction

    function automatic string tag_of(logic [7:0] cur, logic c, logic l,
                                     logic p, logic t, logic [1:0] m,
                                     logic [7:0] d);
        if (!c) return "R1";
        if (m == 2'b10 && cur == d) return "R8";
        if (!l) return "R2";
        if (m == 2'b01 && exp_carry(cur, t)) return "R7";
        if (p && t) return (cur[3:0] == 4'hF) ? "R6" : "R3";
        return "R4";
    endfunction

    task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(logic c, logic l, logic p, logic t, logic [1:0] m,
                        logic [7:0] d);
        logic [7:0] nxt;
        string tg;
        @(negedge clk);
        clr_n = c; ld_n = l; en_p = p; en_t = t; wrap_mode = m; din = d;
        #1;
        if (known) begin
            chk(carry == exp_carry(model, t), "R5", {7'd0, carry},
                {7'd0, exp_carry(model, t)});
            chk(q == model, "R1", q, model);
            nxt = next_val(model, c, l, p, t, m, d);
            tg  = tag_of(model, c, l, p, t, m, d);
        end else begin
            nxt = 8'h00;
            tg  = "R1";
        end
        @(posedge clk);
        #1;
        if (known || !c) begin
            chk(q == nxt, tg, q, nxt);
            model = nxt;
            known = 1;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // reset state via clear (R1)
        step(0, 0, 1, 1, 2'b00, 8'hAA);
        chk(carry == 1'b0, "R1", {7'd0, carry}, 8'h00);
        // load with enables low (R2), then hold (R4)
        step(1, 0, 0, 0, 2'b00, 8'h0C);
        step(1, 1, 0, 1, 2'b00, 8'h00);
        step(1, 1, 1, 0, 2'b00, 8'h00);
        // count across the nibble boundary (R3, R6)
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 2'b00, 8'h00);
        chk(q == 8'h11, "R6", q, 8'h11);
        // terminal carry and wrap (R5, R3)
        step(1, 0, 1, 1, 2'b00, 8'hFE);
        step(1, 1, 1, 1, 2'b00, 8'h00);
        step(1, 1, 0, 1, 2'b00, 8'h00);
        step(1, 1, 1, 0, 2'b00, 8'h00);
        step(1, 1, 1, 1, 2'b00, 8'h00);
        chk(q == 8'h00, "R3", q, 8'h00);
        // clear beats load (R1)
        step(1, 0, 1, 1, 2'b00, 8'h55);
        step(0, 0, 1, 1, 2'b00, 8'h55);
        // reload mode (R7)
        step(1, 0, 1, 1, 2'b00, 8'hFD);
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 2'b01, 8'h06);
        chk(q == 8'h08, "R7", q, 8'h08);
        // truncate mode (R8)
        step(0, 1, 1, 1, 2'b10, 8'h0D);
        for (int i = 0; i < 16; i++) step(1, 1, 1, 1, 2'b10, 8'h0D);
        chk(q == 8'h02, "R8", q, 8'h02);
        step(1, 0, 0, 0, 2'b00, 8'h0D);
        step(1, 1, 0, 0, 2'b10, 8'h0D);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic c, l, p, t;
            logic [1:0] m;
            logic [7:0] d;
            c = ($urandom % 25) != 0;
            l = ($urandom % 12) != 0;
            p = ($urandom % 5) != 0;
            t = ($urandom % 5) != 0;
            m = 2'($urandom % 4);
            d = ($urandom % 3 == 0) ? 8'hF0 + 8'($urandom % 16) : 8'($urandom);
            step(c, l, p, t, m, d);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule